// File: doc/BRIEF.md
# Serial Flash Read Window

This block is a read-only bus slave that exposes a serial flash array through a 128 MiB slice of the host address space. A bus read that lands in the slice becomes one flash data-read transaction on the serial pins. That transaction carries a command byte, a 24-bit byte address and 32 clocks of returned data. The block holds the bus ready signal low until the whole word has arrived, then presents it for one cycle. Flash contents are laid out little-endian. A big-endian host therefore needs each word byte-swapped before it sees bytes in storage order. The block applies that swap on every read through the window.

The serial pins are shared with a separate command engine. The two sides exclude each other through a pair of busy flags. The window waits while the engine reports busy. The engine must not start while the window reports busy. Writes aimed at the window change nothing: they are acknowledged with an error flag. Requests outside the window are left for other slaves to answer.

Top module: `sflash_rd_window`

## Requirements
- R1: A request is taken only when address bits 31:27 equal 5'b00001, which covers 0x0800_0000 through 0x0FFF_FFFF. For any other address the block never raises bus_ready, never lowers spi_cs_n and never raises win_busy.
- R2: Each window read performs one transaction while spi_cs_n is low. During the first 32 sck pulses spi_mosi carries, MSB first, the command byte 8'h03 followed by the 24-bit flash address. That address is window offset bits 23:0 with bits 1:0 forced to zero.
- R3: Bytes arrive on spi_miso MSB first. The word given on bus_rdata holds the first byte returned in bits 31:24, the second in bits 23:16, the third in 15:8 and the fourth in 7:0.
- R4: When the engine is idle, bus_ready rises in the 130th clock cycle after the first edge that samples the read request. It stays high for exactly one cycle, and bus_err stays low.
- R5: Address bits 1:0 have no effect: offsets +1, +2 and +3 return the same word as the aligned address.
- R6: A bus write inside the window gets bus_ready and bus_err high together for one cycle, in the cycle after the first edge that samples it. No serial transaction takes place, and bus_err is never high without bus_ready.
- R7: Suppose eng_busy is sampled high on edges 1 through H (H ≥ 1) of a read. Then spi_cs_n stays high over that span, and bus_ready arrives H+129 cycles after the request. A transaction starts only if eng_busy was low on the edge before spi_cs_n falls.
- R8: win_busy is high from the first edge after a window read is taken until the transaction ends. spi_cs_n is low only while win_busy is high. win_busy is low in the cycle that bus_ready is presented.
- R9: The serial clock idles low whenever spi_cs_n is high. Each transaction gives exactly 64 rising edges of spi_sck.
- R10: While reset is held and after it is released, spi_cs_n is high, and spi_sck, bus_ready, bus_err and win_busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Request valid; held until bus_ready is seen |
| bus_we | input | 1 | Request is a write |
| bus_addr | input | 32 | Request byte address |
| bus_rdata | output | 32 | Read word, valid with bus_ready |
| bus_ready | output | 1 | One-cycle completion strobe |
| bus_err | output | 1 | Write to the window rejected |
| eng_busy | input | 1 | Command engine owns the serial pins |
| win_busy | output | 1 | Window owns or is claiming the serial pins |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Each read result falls due at a fixed edge. That edge is 130 edges after the request when the engine is idle, or H+129 when eng_busy is held for H edges. A write acknowledgement falls due one edge after the request. The bench counts rising edges from the first edge that samples the request and reads the outputs at the following falling edge. It compares the measured count with these figures as well as checking the data. A flash model built from the serial pins computes each byte arithmetically from its address. This lets every read word, captured command and pulse count be predicted without looking inside the design. One cycle after each strobe the bench confirms that bus_ready has dropped.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

    localparam int          WORD_W    = 32;
    localparam int          WORD_B    = WORD_W / 8;
    localparam logic [7:0]  RD_OPCODE = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_RESP,
        ST_WERR
    } seq_state_t;

    // Reverse byte order of a word.
    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_B; i++) begin
            r[8*i +: 8] = w[8*(WORD_B-1-i) +: 8];
        end
        return r;
    endfunction

    // Serial stream holds first byte at the top; storage is little-endian,
    // so the stored word value has the first byte at the bottom.
    function automatic logic [WORD_W-1:0] stream_to_le(input logic [WORD_W-1:0] s);
        return swap_bytes(s);
    endfunction

endpackage

// File: rtl/sfw_decode.sv
module sfw_decode #(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0800_0000,
    parameter int                WIN_LOG2 = 27,
    parameter int                FLASH_AW = 24
) (
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic                rd_hit,
    output logic                wr_hit,
    output logic [FLASH_AW-1:0] flash_addr
);
    logic in_win;
    logic unused_offset_bits;

    assign in_win     = (bus_addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
    assign rd_hit     = bus_sel & in_win & ~bus_we;
    assign wr_hit     = bus_sel & in_win &  bus_we;
    assign flash_addr = {bus_addr[FLASH_AW-1:2], 2'b00};

    generate
        if (WIN_LOG2 > FLASH_AW) begin : g_wrap
            assign unused_offset_bits = ^{bus_addr[WIN_LOG2-1:FLASH_AW], bus_addr[1:0]};
        end else begin : g_exact
            assign unused_offset_bits = ^bus_addr[1:0];
        end
    endgenerate
endmodule

// File: rtl/sfw_seq.sv
module sfw_seq
    import sfw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic eng_busy,
    input  logic xfer_done,
    output logic xfer_load,
    output logic xfer_run,
    output logic bus_ready,
    output logic bus_err,
    output logic win_busy
);
    seq_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (rd_hit)      nxt = ST_WAIT;
                else if (wr_hit) nxt = ST_WERR;
            end
            ST_WAIT: if (!eng_busy) nxt = ST_XFER;
            ST_XFER: if (xfer_done) nxt = ST_RESP;
            ST_RESP: nxt = ST_IDLE;
            ST_WERR: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign xfer_load = (state == ST_WAIT) & ~eng_busy;
    assign xfer_run  = (state == ST_XFER);
    assign bus_ready = (state == ST_RESP) | (state == ST_WERR);
    assign bus_err   = (state == ST_WERR);
    assign win_busy  = (state == ST_WAIT) | (state == ST_XFER);
endmodule

// File: rtl/sfw_shift.sv
module sfw_shift
    import sfw_pkg::*;
#(
    parameter int FLASH_AW = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [FLASH_AW-1:0] flash_addr,
    input  logic                run,
    input  logic                miso,
    output logic                sck,
    output logic                mosi,
    output logic                done,
    output logic [WORD_W-1:0]   rdata
);
    localparam int TX_BITS = 8 + FLASH_AW;
    localparam int TOTAL   = TX_BITS + WORD_W;
    localparam int CW      = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] TX_END = CW'(TX_BITS);
    localparam logic [CW-1:0] LAST   = CW'(TOTAL - 1);

    logic [TX_BITS-1:0] tx_sr;
    logic [WORD_W-1:0]  rx_sr;
    logic [WORD_W-1:0]  rdata_q;
    logic [CW-1:0]      bit_cnt;
    logic               sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            rdata_q <= '0;
            bit_cnt <= '0;
            sck_q   <= 1'b0;
        end else if (load) begin
            tx_sr   <= {RD_OPCODE, flash_addr};
            bit_cnt <= '0;
            sck_q   <= 1'b0;
        end else if (run) begin
            if (!sck_q) begin
                sck_q <= 1'b1;
                if (bit_cnt >= TX_END) rx_sr <= {rx_sr[WORD_W-2:0], miso};
            end else begin
                sck_q   <= 1'b0;
                tx_sr   <= tx_sr << 1;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST) rdata_q <= swap_bytes(stream_to_le(rx_sr));
            end
        end
    end

    assign sck   = sck_q;
    assign mosi  = run & (bit_cnt < TX_END) & tx_sr[TX_BITS-1];
    assign done  = run & sck_q & (bit_cnt == LAST);
    assign rdata = rdata_q;
endmodule

// File: rtl/sflash_rd_window.sv
module sflash_rd_window
    import sfw_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] WIN_BASE = 32'h0800_0000,
    parameter int          WIN_LOG2 = 27,
    parameter int          FLASH_AW = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              bus_err,
    input  logic              eng_busy,
    output logic              win_busy,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic                rd_hit, wr_hit;
    logic [FLASH_AW-1:0] flash_addr;
    logic                xfer_load, xfer_run, xfer_done;

    sfw_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE[ADDR_W-1:0]),
        .WIN_LOG2 (WIN_LOG2),
        .FLASH_AW (FLASH_AW)
    ) u_decode (
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .rd_hit     (rd_hit),
        .wr_hit     (wr_hit),
        .flash_addr (flash_addr)
    );

    sfw_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .rd_hit    (rd_hit),
        .wr_hit    (wr_hit),
        .eng_busy  (eng_busy),
        .xfer_done (xfer_done),
        .xfer_load (xfer_load),
        .xfer_run  (xfer_run),
        .bus_ready (bus_ready),
        .bus_err   (bus_err),
        .win_busy  (win_busy)
    );

    sfw_shift #(
        .FLASH_AW (FLASH_AW)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (xfer_load),
        .flash_addr (flash_addr),
        .run        (xfer_run),
        .miso       (spi_miso),
        .sck        (spi_sck),
        .mosi       (spi_mosi),
        .done       (xfer_done),
        .rdata      (bus_rdata)
    );

    assign spi_cs_n = ~xfer_run;
endmodule

// File: rtl/sfw_checker.sv
module sfw_checker (
    input logic clk,
    input logic rst,
    input logic bus_ready,
    input logic bus_err,
    input logic eng_busy,
    input logic win_busy,
    input logic spi_cs_n,
    input logic spi_sck
);
    // R6: the error flag only accompanies an acknowledgement
    p_err_with_ready_r6: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> bus_ready);

    // R4: the strobe lasts a single cycle
    p_ready_single_r4: assert property (@(posedge clk) disable iff (rst)
        bus_ready |=> !bus_ready);

    // R7: a transaction only begins after the engine was seen idle
    p_start_after_idle_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> !$past(eng_busy));

    // R8: the pins are driven only while the window claims them
    p_cs_claimed_r8: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> win_busy);

    // R8: acknowledgement comes after the pins are released
    p_ready_released_r8: assert property (@(posedge clk) disable iff (rst)
        bus_ready |-> (spi_cs_n && !win_busy));

    // R9: serial clock rests low between transactions
    p_sck_idle_r9: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);
endmodule

bind sflash_rd_window sfw_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .eng_busy  (eng_busy),
    .win_busy  (win_busy),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck)
);

// File: tb/sflash_rd_window_tb_top.sv
module sflash_rd_window_tb_top;
    // 125 MHz: 8-unit period
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready, bus_err;
    logic        eng_busy = 1'b0;
    logic        win_busy;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sflash_rd_window dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .bus_err(bus_err), .eng_busy(eng_busy), .win_busy(win_busy),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // flash contents: computed per byte address
    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'hA5;
    endfunction

    // flash model on the serial pins
    int          rise_cnt = 0;
    logic [31:0] cmd_cap = '0;

    always @(negedge spi_cs_n) begin
        rise_cnt = 0;
        cmd_cap  = '0;
    end

    always @(posedge spi_sck) begin
        if (rise_cnt < 32) cmd_cap = {cmd_cap[30:0], spi_mosi};
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge spi_sck) begin
        if (rise_cnt >= 32 && rise_cnt < 64) begin
            int          idx;
            logic [7:0]  b;
            idx = rise_cnt - 32;
            b   = mem_byte(cmd_cap[23:0] + 24'(idx / 8));
            spi_miso <= b[7 - (idx % 8)];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // hold = number of edges for which eng_busy is sampled high
    task automatic do_read(input logic [31:0] a, input int hold, input string req);
        logic [23:0] fa;
        logic [31:0] exp;
        int          n;
        int          due;
        bit          hold_ok;
        fa  = {a[23:2], 2'b00};
        exp = {mem_byte(fa), mem_byte(fa + 24'd1), mem_byte(fa + 24'd2), mem_byte(fa + 24'd3)};
        due = (hold == 0) ? 130 : hold + 129;
        hold_ok = 1;
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        if (hold > 0) eng_busy = 1;
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (hold > 0 && n < hold && (!spi_cs_n || !win_busy)) hold_ok = 0;
            if (hold > 0 && n == hold) eng_busy = 0;
            if (n == due - 10) begin
                chk(win_busy && !spi_cs_n, "R8 busy during transfer",
                    {30'd0, win_busy, spi_cs_n}, 32'd2);
            end
            if (bus_ready || n > 1000) break;
        end
        if (hold > 1) chk(hold_ok, "R7 pins untouched while engine busy", 32'(hold_ok), 32'd1);
        chk(n == due, (hold > 0) ? "R7 latency with engine busy" : "R4 latency", 32'(n), 32'(due));
        chk(bus_rdata == exp, req, bus_rdata, exp);
        chk(!bus_err, "R4 no error on read", 32'(bus_err), 32'd0);
        chk(!win_busy, "R8 released at ready", 32'(win_busy), 32'd0);
        chk(cmd_cap == {8'h03, fa}, "R2 command and address", cmd_cap, {8'h03, fa});
        chk(rise_cnt == 64, "R9 sck pulse count", 32'(rise_cnt), 32'd64);
        bus_sel = 0;
        @(posedge clk);
        @(negedge clk);
        chk(!bus_ready && spi_cs_n && !spi_sck, "R4 R9 strobe dropped, pins idle",
            {29'd0, bus_ready, spi_cs_n, spi_sck}, 32'd2);
    endtask

    task automatic do_write(input logic [31:0] a);
        bit cs_seen;
        cs_seen = 0;
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        chk(bus_ready && bus_err, "R6 write acknowledged with error",
            {30'd0, bus_ready, bus_err}, 32'd3);
        bus_sel = 0; bus_we = 0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (!spi_cs_n || bus_ready || bus_err) cs_seen = 1;
        end
        chk(!cs_seen, "R6 write leaves pins and bus quiet", 32'(cs_seen), 32'd0);
    endtask

    task automatic do_miss(input logic [31:0] a, input bit we);
        bit act;
        act = 0;
        @(negedge clk);
        bus_sel = 1; bus_we = we; bus_addr = a;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (bus_ready || !spi_cs_n || win_busy || bus_err) act = 1;
        end
        chk(!act, "R1 outside window ignored", a, 32'd0);
        bus_sel = 0; bus_we = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(spi_cs_n && !spi_sck && !bus_ready && !bus_err && !win_busy,
            "R10 state during reset",
            {27'd0, spi_cs_n, spi_sck, bus_ready, bus_err, win_busy}, 32'h10);
        rst = 0;
        @(posedge clk);
        @(negedge clk);
        chk(spi_cs_n && !spi_sck && !bus_ready && !bus_err && !win_busy,
            "R10 state after reset",
            {27'd0, spi_cs_n, spi_sck, bus_ready, bus_err, win_busy}, 32'h10);

        // window boundaries (R1, R3)
        do_read(32'h0800_0000, 0, "R1 R3 window start data");
        do_read(32'h0FFF_FFFC, 0, "R1 R3 window end data");
        do_read(32'h0FFF_FFFF, 0, "R5 R1 last byte of window");
        do_miss(32'h07FF_FFFC, 0);
        do_miss(32'h1000_0000, 0);
        do_miss(32'h0000_0000, 0);
        do_miss(32'hF800_0000, 1);

        // alignment sweep (R5)
        for (int k = 0; k < 4; k++) begin
            do_read(32'h0812_3450 + 32'(k), 0, "R5 low bits ignored");
        end

        // address and engine-hold sweep (R3, R7)
        for (int i = 0; i < 16; i++) begin
            int h;
            h = (i % 4 == 0) ? 0 : (i % 4 == 1) ? 1 : (i % 4 == 2) ? 2 : 5;
            do_read(32'h0800_0000 + 32'(i) * 32'h0072_3457, h, "R3 R7 sweep data");
        end

        // writes into the window (R6), then the same word still reads back
        do_write(32'h0800_0100);
        do_read(32'h0800_0100, 0, "R6 flash unchanged after write");
        do_write(32'h0FFF_FFFE);

        finished = 1;
        summary();
        $finish;
    end
endmodule